// File: doc/BRIEF.md
# Scaled FP32 to FP8 Quantizer

This block converts one IEEE single-precision value per cycle into an 8-bit floating-point code. Each input carries a signed power-of-two scale exponent and a format select. The scale is not applied with a multiplier. It is added directly to the unbiased input exponent, in the same adder that rebiases the value for the target format. The scaled value is then rounded to nearest with ties to even on the FP8 grid, subnormals included. It is clamped to the largest finite magnitude when it does not fit.

The two target layouts are:

| Select | Sign bits | Exponent bits | Mantissa bits | Bias |
|--------|-----------|---------------|---------------|------|
| `in_fmt=0` | 1 | 4 | 3 | 7 |
| `in_fmt=1` | 1 | 5 | 2 | 15 |

A quantization datapath uses this block at the point where wide activations or weights are written out in 8-bit form. Input and output each use a valid/ready handshake. One output register sits between the two handshakes, and that register can accept a new value in the same cycle that it hands the old one on.

Top module: `fp8_quant`

## Requirements
- R1: With `in_fmt=0`, the code is {sign, 4-bit exponent biased by 7, 3-bit mantissa}. A finite input is rounded to nearest, and an exact tie goes to the code with an even least significant bit. For example, 1.0 gives 0x38, 1.0625 gives 0x38 and 1.1875 gives 0x3A.
- R2: With `in_fmt=1`, the code is {sign, 5-bit exponent biased by 15, 2-bit mantissa}, with the same nearest-even rounding. For example, 1.0 gives 0x3C, 1.125 gives 0x3C and 1.375 gives 0x3E.
- R3: The signed two's-complement `in_scale` multiplies the value by 2^in_scale before rounding. A mantissa that rounds up from all ones carries into the exponent. For example, 1000.0 with scale -4 gives 0x68 in the 4/3 layout.
- R4: A scaled value below the smallest normal is rounded into the subnormal codes (exponent field 0) with nearest-even rounding. This can round up to the smallest normal, or down to signed zero.
- R5: A finite value whose rounded magnitude exceeds the largest finite code saturates to that code with the sign kept. The largest finite code is 0x7E (448) in the 4/3 layout and 0x7B (57344) in the 5/2 layout. The overflow test is applied after rounding.
- R6: An FP32 NaN of either sign produces 0x7F in both layouts.
- R7: An FP32 infinity produces {sign, 0x7E} in the 4/3 layout, which has no infinity. It produces {sign, 0x7C}, an infinity, in the 5/2 layout.
- R8: The sign of every non-NaN input is kept. A zero input gives signed zero. FP32 subnormal inputs are normalized before scaling, so a large enough scale lifts them into range; otherwise they round to signed zero.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An accepted input appears on `out_code`, with `out_valid` high, after the next rising edge. While `out_valid` is high and `out_ready` is low, `out_code` and `out_valid` hold.
- R10: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input holds a value to convert |
| in_ready | output | 1 | Block accepts the input this cycle |
| in_data | input | 32 | IEEE single-precision value |
| in_scale | input | SCALE_W | Signed power-of-two scale exponent |
| in_fmt | input | 1 | 0: 4/3 layout, 1: 5/2 layout |
| out_valid | output | 1 | Output code is valid |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_code | output | 8 | FP8 code |

## Verification
The conversion is a single combinational path into one output register, so any internal fault shows on `out_code` one cycle after the faulty input is accepted.

Faults show up as follows:
- A wrong rebiased exponent or a misplaced scale addition moves every affected code by whole binades.
- A wrong guard or sticky bit changes only the least significant code bit on ties and near-ties.
- A missed carry or a late overflow test produces a NaN or infinity pattern where a saturated maximum was expected.
- A handshake fault shows as `out_code` changing, or as a value being lost, while the consumer stalls.

// File: rtl/fp8_quant.sv
module fp8_quant #(
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic               in_fmt,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_code
);
  localparam int EW = ((SCALE_W > 9) ? SCALE_W : 9) + 2;

  logic        sgn;
  logic [7:0]  e32;
  logic [22:0] f32;
  logic        is_nan, is_inf, is_zero, is_sub;
  logic [4:0]  lead;

  assign sgn     = in_data[31];
  assign e32     = in_data[30:23];
  assign f32     = in_data[22:0];
  assign is_nan  = (e32 == 8'hFF) && (f32 != '0);
  assign is_inf  = (e32 == 8'hFF) && (f32 == '0);
  assign is_zero = (e32 == 8'h00) && (f32 == '0);
  assign is_sub  = (e32 == 8'h00) && (f32 != '0);

  always_comb begin
    lead = '0;
    for (int i = 0; i < 23; i++)
      if (f32[i]) lead = 5'(i);
  end

  logic signed [EW-1:0] e_unb, e_reb, e_neg;
  logic [23:0]          sig;
  logic [4:0]           sh;
  logic [55:0]          wide;

  assign e_unb = is_sub ? (EW'(lead) - EW'(149)) : (EW'(e32) - EW'(127));
  assign e_reb = e_unb + EW'($signed(in_scale)) + (in_fmt ? EW'(15) : EW'(7));
  assign e_neg = EW'(1) - e_reb;
  assign sig   = is_sub ? ({1'b0, f32} << (5'd23 - lead)) : {1'b1, f32};
  assign sh    = (e_reb > 0) ? 5'd0 : ((e_neg > 31) ? 5'd31 : e_neg[4:0]);
  assign wide  = {sig, 32'b0} >> sh;

  logic [EW-1:0] expf;
  logic          inc4, inc5;
  logic [EW+2:0] mag4;
  logic [EW+1:0] mag5;

  assign expf = wide[55] ? e_reb : '0;
  assign inc4 = wide[51] && ((|wide[50:0]) || wide[52]);
  assign inc5 = wide[52] && ((|wide[51:0]) || wide[53]);
  assign mag4 = {expf, wide[54:52]} + (EW+3)'(inc4);
  assign mag5 = {expf, wide[54:53]} + (EW+2)'(inc5);

  logic [7:0] conv;

  always_comb begin
    if (is_nan)
      conv = 8'h7F;
    else if (is_inf)
      conv = in_fmt ? {sgn, 7'h7C} : {sgn, 7'h7E};
    else if (is_zero)
      conv = {sgn, 7'h00};
    else if (in_fmt)
      conv = (mag5 > (EW+2)'('h7B)) ? {sgn, 7'h7B} : {sgn, mag5[6:0]};
    else
      conv = (mag4 > (EW+3)'('h7E)) ? {sgn, 7'h7E} : {sgn, mag4[6:0]};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= 8'h00;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_code  <= conv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fp8_quant_chk.sv
module fp8_quant_chk #(
  parameter int SCALE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        in_data,
  input logic [SCALE_W-1:0] in_scale,
  input logic               in_fmt,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_code
);
  logic fire, nan_in, finite_in;
  assign fire      = in_valid && in_ready;
  assign nan_in    = (in_data[30:23] == 8'hFF) && (in_data[22:0] != '0);
  assign finite_in = (in_data[30:23] != 8'hFF);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code)); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid); // R9
  AST_NAN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && nan_in |=> out_code == 8'h7F); // R6
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !nan_in |=> out_code[7] == $past(in_data[31])); // R8
  AST_E4M3_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && finite_in && !in_fmt |=> out_code[6:0] != 7'h7F); // R5
  AST_E5M2_FINITE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && finite_in && in_fmt |=> out_code[6:0] < 7'h7C); // R5
endmodule

bind fp8_quant fp8_quant_chk #(.SCALE_W(SCALE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_scale(in_scale), .in_fmt(in_fmt),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
);

// File: tb/fp8_quant_tb.sv
module fp8_quant_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  // {data, scale, fmt, expected}
  localparam logic [48:0] VEC [NV] = '{
    {32'h3F800000, 8'h00, 1'b0, 8'h38},  // R1 1.0
    {32'hBFC00000, 8'h00, 1'b0, 8'hBC},  // R1 -1.5
    {32'h3F880000, 8'h00, 1'b0, 8'h38},  // R1 tie down
    {32'h3F980000, 8'h00, 1'b0, 8'h3A},  // R1 tie up
    {32'h3F890000, 8'h00, 1'b0, 8'h39},  // R1 above half
    {32'h3F800000, 8'h00, 1'b1, 8'h3C},  // R2 1.0
    {32'h3FB00000, 8'h00, 1'b1, 8'h3E},  // R2 tie up
    {32'h3F900000, 8'h00, 1'b1, 8'h3C},  // R2 tie down
    {32'h3F800000, 8'h03, 1'b0, 8'h50},  // R3 +3
    {32'h3F800000, 8'hFB, 1'b1, 8'h28},  // R3 -5
    {32'h447A0000, 8'hFC, 1'b0, 8'h68},  // R3 carry into exponent
    {32'h3F800000, 8'hF7, 1'b0, 8'h01},  // R4 min subnormal
    {32'h3F800000, 8'hF6, 1'b0, 8'h00},  // R4 tie to zero
    {32'h3FC00000, 8'hF6, 1'b0, 8'h01},  // R4 round up
    {32'h3F800000, 8'hF0, 1'b1, 8'h01},  // R4 e5m2 subnormal
    {32'h3FC00000, 8'hF9, 1'b0, 8'h06},  // R4 0.75*2^-6
    {32'h3FF80000, 8'hF9, 1'b0, 8'h08},  // R4 up to min normal
    {32'h3F800000, 8'h80, 1'b1, 8'h00},  // R4 far underflow
    {32'hBF800000, 8'h80, 1'b0, 8'h80},  // R4 signed underflow
    {32'h43E00000, 8'h00, 1'b0, 8'h7E},  // R5 448
    {32'h43E80000, 8'h00, 1'b0, 8'h7E},  // R5 464 tie
    {32'h43F00000, 8'h00, 1'b0, 8'h7E},  // R5 480 saturate
    {32'hBF800000, 8'h14, 1'b0, 8'hFE},  // R5 -2^20
    {32'h47600000, 8'h00, 1'b1, 8'h7B},  // R5 57344
    {32'h47700000, 8'h00, 1'b1, 8'h7B},  // R5 round then saturate
    {32'hBF800000, 8'h14, 1'b1, 8'hFB},  // R5 e5m2 negative
    {32'h3F800000, 8'h7F, 1'b0, 8'h7E},  // R5 max scale
    {32'h7FC00000, 8'h00, 1'b0, 8'h7F},  // R6
    {32'hFFC00001, 8'h00, 1'b1, 8'h7F},  // R6
    {32'h7F800001, 8'h05, 1'b0, 8'h7F},  // R6
    {32'h7F800000, 8'h00, 1'b0, 8'h7E},  // R7
    {32'hFF800000, 8'h00, 1'b1, 8'hFC},  // R7
    {32'hFF800000, 8'hF0, 1'b0, 8'hFE},  // R7
    {32'h00000000, 8'h00, 1'b0, 8'h00},  // R8 +0
    {32'h80000000, 8'h00, 1'b1, 8'h80},  // R8 -0
    {32'h00000001, 8'h00, 1'b0, 8'h00},  // R8 tiny subnormal
    {32'h80000001, 8'h7F, 1'b1, 8'h80},  // R8 subnormal not lifted
    {32'h00400000, 8'h7F, 1'b0, 8'h38},  // R8 subnormal lifted
    {32'h80400000, 8'h7F, 1'b1, 8'hBC}   // R8 subnormal lifted e5m2
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [7:0]  in_scale = '0;
  logic        in_fmt = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [7:0]  out_code;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp8_quant #(.SCALE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_scale(in_scale), .in_fmt(in_fmt),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", {7'b0, out_valid}, 8'h00);
    check("R10 in_ready in reset", {7'b0, in_ready}, 8'h01);
    rst_n = 1;
    @(negedge clk);
    check("R10 out_valid after reset", {7'b0, out_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      in_data  = VEC[i][48:17];
      in_scale = VEC[i][16:9];
      in_fmt   = VEC[i][8];
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check($sformatf("R1-table vector %0d valid (R9)", i), {7'b0, out_valid}, 8'h01);
      check($sformatf("table vector %0d data", i), out_code, VEC[i][7:0]);
    end
    @(negedge clk);
    check("R9 out_valid drops when idle", {7'b0, out_valid}, 8'h00);

    // R9 stall: hold output, refuse input, then hand over in one edge
    out_ready = 0;
    in_data = 32'h3F800000; in_scale = 8'h00; in_fmt = 0; in_valid = 1;
    @(negedge clk);
    check("R9 first accepted", out_code, 8'h38);
    in_data = 32'hBFC00000;
    check("R9 in_ready low on stall", {7'b0, in_ready}, 8'h00);
    @(negedge clk);
    check("R9 code held in stall", out_code, 8'h38);
    check("R9 valid held in stall", {7'b0, out_valid}, 8'h01);
    out_ready = 1;
    #1;
    check("R9 in_ready follows out_ready", {7'b0, in_ready}, 8'h01);
    @(negedge clk);
    in_valid = 0;
    check("R9 next value after release", out_code, 8'hBC);
    check("R9 valid after release", {7'b0, out_valid}, 8'h01);

    // R10 reset clears a pending output
    out_ready = 0;
    rst_n = 0;
    @(negedge clk);
    check("R10 reset clears valid", {7'b0, out_valid}, 8'h00);
    rst_n = 1;
    out_ready = 1;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule